// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit single-precision binary floating-point words in a four-stage pipeline. The stages run in a fixed order. The first stage sorts each operand pair into a path: a normal arithmetic pair, a pair with one zero operand, or a pair with two zero operands. The second stage restores the hidden leading one of each operand and shifts the mantissa of the smaller operand into line with the larger exponent. The third stage adds or subtracts the aligned mantissas into a field one bit wider than the mantissa, so that the carry is kept. The fourth stage normalizes the result, packs it and raises status bits.

A single operation bit selects subtraction. Subtraction inverts the sign of the second operand as it enters the pipeline, so the later stages only ever add signed values. A zero operand is detected once, at entry, and a path tag carries that decision to the end of the pipeline. The result is truncated; there is no rounding. An exponent field of zero counts as a zero operand, so denormal inputs are flushed to zero.

A new operand pair may be presented on every clock. The result returns with a valid strobe a fixed number of cycles later, in issue order.

Top module: `fp_addsub_pipe`

## Requirements
- R1: An operand pair sampled with `in_valid` high at a rising edge appears on `result`/`status` with `out_valid` high right after the fourth rising edge, counting the sampling edge. Pairs issued on consecutive clocks emerge on consecutive clocks, in order.
- R2: While `rst` is high and after it is released, with no pairs issued, `out_valid`, `result` and `status` are all zero.
- R3: Two operands of the same effective sign are added. A carry out of the mantissa increments the exponent, and the fraction becomes the upper bits of the sum (for example, 1.0 + 1.0 = 0x40000000).
- R4: With `op_sub` = 1 the sign of `opnd_b` is inverted before any arithmetic. The result then equals `opnd_a` plus the negated `opnd_b`.
- R5: For effective signs that differ, the smaller aligned mantissa is subtracted from the larger, and the result takes the sign of the larger-magnitude operand. An exact zero gives +0 (0x00000000) with `status` = 4'b0001.
- R6: A result mantissa without a carry is shifted left until its leading bit is 1. The exponent drops by one for each shift.
- R7: The mantissa of the operand with the smaller exponent is shifted right by the exponent difference, and the bits shifted out are discarded. A difference of 25 or more contributes nothing.
- R8: An operand whose exponent field is 0 is a zero operand. If exactly one operand is zero, the result is the other operand, with the inverted sign when it is `opnd_b` under subtraction, and `status` = 4'b1000. If both operands are zero, the result is 0x00000000 and `status` = 4'b1001.
- R9: If incrementing the exponent reaches 255, the result is the signed infinity pattern (exponent 0xFF, fraction 0) and `status` = 4'b0010. An increment that stops at 254 is an ordinary result.
- R10: If normalization would drive the exponent below 1, the result is 0x00000000 and `status` = 4'b0101.
- R11: A clock with `in_valid` low issues nothing. No extra `out_valid` pulse appears for it, whatever the operand inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue the operand pair on this edge |
| op_sub | input | 1 | 0 = add, 1 = subtract `opnd_b` from `opnd_a` |
| opnd_a | input | 32 | First operand, single precision |
| opnd_b | input | 32 | Second operand, single precision |
| out_valid | output | 1 | `result` and `status` hold a finished operation |
| result | output | 32 | Sum or difference, single precision |
| status | output | 4 | bit0 zero result, bit1 overflow, bit2 underflow, bit3 zero-operand bypass |

## Verification
The hardest condition to reach from the ports is underflow. It needs a subtraction of two operands that are both near the smallest normal exponent, and whose aligned mantissas cancel far enough that the left shift pushes the exponent below one. The stimulus table reaches it by subtracting 1.5 times the minimum normal value from the minimum normal value. The table also holds alignment distances of exactly 23, 24 and 25 and a carry that reaches exponent 255 or stops at 254. All vectors are issued back to back, with one idle slot in the middle, so that the later stages always hold neighbouring operations of different kinds.

// File: rtl/fpas_pkg.sv
package fpas_pkg;

    localparam int EXP_W       = 8;
    localparam int FRAC_W      = 23;
    localparam int MANT_W      = FRAC_W + 1;
    localparam int WORD_W      = 1 + EXP_W + FRAC_W;
    localparam int LZ_W        = $clog2(MANT_W + 1);
    localparam int FLUSH_SHIFT = MANT_W + 1;
    localparam int ST_W        = 4;

    localparam int ST_ZERO = 0;
    localparam int ST_OVF  = 1;
    localparam int ST_UNF  = 2;
    localparam int ST_BYP  = 3;

    localparam logic [EXP_W-1:0] EXP_TOP = '1;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef enum logic [1:0] {
        PATH_ARITH  = 2'd0,
        PATH_PASS_A = 2'd1,
        PATH_PASS_B = 2'd2,
        PATH_ZERO   = 2'd3
    } path_e;

    // after zero detection
    typedef struct packed {
        logic     valid;
        path_e    path;
        fp_word_t a;
        fp_word_t b;
    } zc_t;

    // after alignment
    typedef struct packed {
        logic              valid;
        path_e             path;
        fp_word_t          pass;
        logic              sa;
        logic              sb;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] ma;
        logic [MANT_W-1:0] mb;
    } al_t;

    // after add/sub: mant carries one extra bit above the hidden one
    typedef struct packed {
        logic              valid;
        path_e             path;
        fp_word_t          pass;
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W:0]   mant;
        logic              norm;
    } as_t;

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [MANT_W-1:0] m);
        logic [LZ_W-1:0] n;
        n = LZ_W'(MANT_W);
        for (int i = 0; i < MANT_W; i++) begin
            if (m[i]) n = LZ_W'(MANT_W - 1 - i);
        end
        return n;
    endfunction

    function automatic logic is_zero_word(input fp_word_t w);
        return (w.exp == '0);
    endfunction

endpackage

// File: rtl/fpas_zero_stage.sv
module fpas_zero_stage
    import fpas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              op_sub,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    output zc_t               q
);
    fp_word_t a_w;
    fp_word_t b_w;
    path_e    path_d;

    always_comb begin
        a_w      = fp_word_t'(opnd_a);
        b_w      = fp_word_t'(opnd_b);
        b_w.sign = b_w.sign ^ op_sub;
        unique case ({is_zero_word(a_w), is_zero_word(b_w)})
            2'b11:   path_d = PATH_ZERO;
            2'b10:   path_d = PATH_PASS_B;
            2'b01:   path_d = PATH_PASS_A;
            default: path_d = PATH_ARITH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= in_valid;
            if (in_valid) begin
                q.path <= path_d;
                q.a    <= a_w;
                q.b    <= b_w;
            end
        end
    end
endmodule

// File: rtl/fpas_align_stage.sv
module fpas_align_stage
    import fpas_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  zc_t  d,
    output al_t  q
);
    logic              a_zero;
    logic              b_zero;
    logic              a_big;
    logic [EXP_W-1:0]  diff;
    logic [MANT_W-1:0] full_a;
    logic [MANT_W-1:0] full_b;
    logic [MANT_W-1:0] small_sh;
    fp_word_t          pass_d;

    always_comb begin
        a_zero = (d.path == PATH_PASS_B) || (d.path == PATH_ZERO);
        b_zero = (d.path == PATH_PASS_A) || (d.path == PATH_ZERO);
        full_a = {~a_zero, d.a.frac};
        full_b = {~b_zero, d.b.frac};
        a_big  = (d.a.exp >= d.b.exp);
        diff   = a_big ? (d.a.exp - d.b.exp) : (d.b.exp - d.a.exp);
        if (diff >= EXP_W'(FLUSH_SHIFT))
            small_sh = '0;
        else
            small_sh = (a_big ? full_b : full_a) >> diff;
        unique case (d.path)
            PATH_PASS_A: pass_d = d.a;
            PATH_PASS_B: pass_d = d.b;
            default:     pass_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= d.valid;
            if (d.valid) begin
                q.path <= d.path;
                q.pass <= pass_d;
                q.sa   <= d.a.sign;
                q.sb   <= d.b.sign;
                q.exp  <= a_big ? d.a.exp : d.b.exp;
                q.ma   <= a_big ? full_a : small_sh;
                q.mb   <= a_big ? small_sh : full_b;
            end
        end
    end
endmodule

// File: rtl/fpas_addsub_stage.sv
module fpas_addsub_stage
    import fpas_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  al_t  d,
    output as_t  q
);
    logic [MANT_W:0] mant_d;
    logic            sign_d;

    always_comb begin
        if (d.sa == d.sb) begin
            mant_d = {1'b0, d.ma} + {1'b0, d.mb};
            sign_d = d.sa;
        end else if (d.ma >= d.mb) begin
            mant_d = {1'b0, d.ma} - {1'b0, d.mb};
            sign_d = (d.ma == d.mb) ? 1'b0 : d.sa;
        end else begin
            mant_d = {1'b0, d.mb} - {1'b0, d.ma};
            sign_d = d.sb;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= d.valid;
            if (d.valid) begin
                q.path <= d.path;
                q.pass <= d.pass;
                q.exp  <= d.exp;
                q.mant <= mant_d;
                q.sign <= sign_d;
                q.norm <= (d.path == PATH_ARITH);
            end
        end
    end
endmodule

// File: rtl/fpas_norm_stage.sv
module fpas_norm_stage
    import fpas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  as_t               d,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic [ST_W-1:0]   status
);
    logic [EXP_W:0]          exp_inc;
    logic [LZ_W-1:0]         lz;
    logic [MANT_W-1:0]       shifted;
    logic signed [EXP_W+1:0] exp_dec;
    fp_word_t                res_d;
    logic [ST_W-1:0]         st_d;

    always_comb begin
        exp_inc = {1'b0, d.exp} + (EXP_W+1)'(1);
        lz      = lead_zeros(d.mant[MANT_W-1:0]);
        shifted = d.mant[MANT_W-1:0] << lz;
        exp_dec = $signed({2'b00, d.exp}) - $signed({{(EXP_W+2-LZ_W){1'b0}}, lz});
        res_d   = '0;
        st_d    = '0;
        if (!d.norm) begin
            st_d[ST_BYP] = 1'b1;
            if (d.path == PATH_ZERO) st_d[ST_ZERO] = 1'b1;
            else                     res_d = d.pass;
        end else if (d.mant == '0) begin
            st_d[ST_ZERO] = 1'b1;
        end else if (d.mant[MANT_W]) begin
            if (exp_inc >= {1'b0, EXP_TOP}) begin
                res_d.sign   = d.sign;
                res_d.exp    = EXP_TOP;
                st_d[ST_OVF] = 1'b1;
            end else begin
                res_d.sign = d.sign;
                res_d.exp  = exp_inc[EXP_W-1:0];
                res_d.frac = d.mant[MANT_W-1:1];
            end
        end else begin
            if (exp_dec[EXP_W+1] || (exp_dec == '0)) begin
                st_d[ST_UNF]  = 1'b1;
                st_d[ST_ZERO] = 1'b1;
            end else begin
                res_d.sign = d.sign;
                res_d.exp  = exp_dec[EXP_W-1:0];
                res_d.frac = shifted[FRAC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            status    <= '0;
        end else begin
            out_valid <= d.valid;
            if (d.valid) begin
                result <= res_d;
                status <= st_d;
            end
        end
    end
endmodule

// File: rtl/fp_addsub_pipe.sv
module fp_addsub_pipe
    import fpas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              op_sub,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic [ST_W-1:0]   status
);
    zc_t s1;
    al_t s2;
    as_t s3;

    fpas_zero_stage u_zero (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .q(s1)
    );

    fpas_align_stage u_align (.clk(clk), .rst(rst), .d(s1), .q(s2));

    fpas_addsub_stage u_addsub (.clk(clk), .rst(rst), .d(s2), .q(s3));

    fpas_norm_stage u_norm (
        .clk(clk), .rst(rst), .d(s3),
        .out_valid(out_valid), .result(result), .status(status)
    );
endmodule

// File: rtl/fpas_checker.sv
module fpas_checker
    import fpas_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic [ST_W-1:0]   status
);
    localparam int DEPTH = 4;
    logic [DEPTH-1:0] issued;

    always_ff @(posedge clk) begin
        if (rst) issued <= '0;
        else     issued <= {issued[DEPTH-2:0], in_valid};
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == issued[DEPTH-1]); // R1

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && status == '0)); // R2

    AST_ZERO_EXACT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && status[ST_ZERO]) |-> (result == '0)); // R5

    AST_OVF_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && status[ST_OVF]) |->
            (result[WORD_W-2 -: EXP_W] == EXP_TOP && result[FRAC_W-1:0] == '0)); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !status[ST_BYP] && !status[ST_OVF]) |->
            (result[WORD_W-2 -: EXP_W] != EXP_TOP)); // R9

    AST_UNF_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (out_valid && status[ST_UNF]) |-> (status[ST_ZERO] && !status[ST_OVF])); // R10

    AST_BYP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && status[ST_BYP]) |-> (!status[ST_OVF] && !status[ST_UNF])); // R8
endmodule

bind fp_addsub_pipe fpas_checker u_fpas_checker (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .out_valid(out_valid), .result(result), .status(status)
);

// File: tb/test_fp_addsub_pipe.sv
`timescale 1ns/1ps
module test_fp_addsub_pipe;
    localparam int N = 19;
    localparam int VW = 101;

    // {op_sub, a, b, expected result, expected status}
    localparam logic [VW-1:0] VEC [N] = '{
        {1'b0, 32'h3F800000, 32'h3F800000, 32'h40000000, 4'h0}, // R3 1+1 carry
        {1'b1, 32'h3FC00000, 32'h3F000000, 32'h3F800000, 4'h0}, // R4 1.5-0.5
        {1'b1, 32'h3F800000, 32'h3F800000, 32'h00000000, 4'h1}, // R5 exact zero
        {1'b0, 32'h40000000, 32'hC0400000, 32'hBF800000, 4'h0}, // R5 sign of larger
        {1'b0, 32'h00000000, 32'h40A00000, 32'h40A00000, 4'h8}, // R8 a zero
        {1'b1, 32'h40A00000, 32'h00000000, 32'h40A00000, 4'h8}, // R8 b zero
        {1'b1, 32'h00000000, 32'h40A00000, 32'hC0A00000, 4'h8}, // R8 b negated
        {1'b0, 32'h00000000, 32'h00000000, 32'h00000000, 4'h9}, // R8 both zero
        {1'b0, 32'h00000001, 32'h3F800000, 32'h3F800000, 4'h8}, // R8 denormal flushed
        {1'b0, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 4'h2}, // R9 overflow
        {1'b1, 32'h00800000, 32'h00C00000, 32'h00000000, 4'h5}, // R10 underflow
        {1'b0, 32'h3F800000, 32'h33800000, 32'h3F800000, 4'h0}, // R7 gap 24
        {1'b0, 32'h3F800000, 32'h33000000, 32'h3F800000, 4'h0}, // R7 gap 25
        {1'b0, 32'h3F800000, 32'h34000000, 32'h3F800001, 4'h0}, // R7 gap 23
        {1'b0, 32'h3F000000, 32'h3F800000, 32'h3FC00000, 4'h0}, // R7 b larger
        {1'b1, 32'h3F800001, 32'h3F800000, 32'h34000000, 4'h0}, // R6 shift 23
        {1'b0, 32'hBF800000, 32'hBF800000, 32'hC0000000, 4'h0}, // R3 negative sum
        {1'b1, 32'h3F800000, 32'hBF800000, 32'h40000000, 4'h0}, // R4 minus negative
        {1'b0, 32'h7E800000, 32'h7E800000, 32'h7F000000, 4'h0}  // R9 stops at 254
    };
    localparam int VREQ [N] = '{3, 4, 5, 5, 8, 8, 8, 8, 8, 9, 10, 7, 7, 7, 7, 6, 3, 4, 9};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  status;

    int checks = 0;
    int errors = 0;
    int out_idx = 0;
    logic mon_en = 1'b0;

    always #2 clk = ~clk;

    fp_addsub_pipe i_fp_addsub_pipe (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .out_valid(out_valid), .result(result), .status(status)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // stream monitor: results must come back in issue order (R1)
    always @(negedge clk) begin
        if (mon_en && out_valid) begin
            if (out_idx < N) begin
                check($sformatf("R%0d vec%0d result", VREQ[out_idx], out_idx),
                      64'(result), 64'(VEC[out_idx][35:4]));
                check($sformatf("R%0d vec%0d status", VREQ[out_idx], out_idx),
                      64'(status), 64'(VEC[out_idx][3:0]));
            end else begin
                check("R11 extra out_valid", 64'(out_idx), 64'(N - 1));
            end
            out_idx++;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2 out_valid in reset", 64'(out_valid), 64'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 out_valid after reset", 64'(out_valid), 64'd0);
        check("R2 result after reset", 64'(result), 64'd0);
        check("R2 status after reset", 64'(status), 64'd0);

        // back-to-back stream with one idle slot (R1, R11)
        mon_en = 1'b1;
        for (int k = 0; k < N; k++) begin
            if (k == 9) begin
                in_valid = 1'b0;
                opnd_a   = 32'h3F800000;
                opnd_b   = 32'h3F800000;
                @(negedge clk);
            end
            in_valid = 1'b1;
            op_sub   = VEC[k][100];
            opnd_a   = VEC[k][99:68];
            opnd_b   = VEC[k][67:36];
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (8) @(negedge clk);
        check("R1 stream output count", 64'(out_idx), 64'(N));
        mon_en = 1'b0;

        // R11: operands change while in_valid is low, nothing comes out
        for (int k = 0; k < 6; k++) begin
            opnd_a = 32'h40400000 + 32'(k);
            opnd_b = 32'h3F800000;
            @(negedge clk);
            check("R11 idle out_valid", 64'(out_valid), 64'd0);
        end

        // R1: exact latency of a single issue
        in_valid = 1'b1;
        op_sub   = 1'b0;
        opnd_a   = 32'h40400000;
        opnd_b   = 32'h3F800000;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 not early", 64'(out_valid), 64'd0);
        @(negedge clk);
        check("R1 valid on fourth edge", 64'(out_valid), 64'd1);
        check("R1 R3 3+1 result", 64'(result), 64'h40800000);
        @(negedge clk);
        check("R1 single pulse", 64'(out_valid), 64'd0);

        // R2: reset mid-flight clears the pipeline
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check("R2 flushed by reset", 64'(out_valid), 64'd0);
        end

        finish_run();
    end
endmodule